// File: doc/BRIEF.md
# System Bus Ownership Arbiter

This block decides, cycle by cycle, who drives the shared system bus: the processor (the default owner), one to three local-bus masters, or a DMA or ISA master requesting through a set of active-low channel request lines. The DMA or ISA side takes the bus only after the processor has been asked to float its bus with a HOLD request and has answered with a hold acknowledge. The hold acknowledge is registered once before use. A local master that owns the bus is pushed off when an unmasked DMA request arrives. Memory refresh is started by a one-cycle go strobe. Refresh never takes the bus away from the processor or a local master, and it is never started while the processor is held.

The DMA engine, the ISA cycle timing and the DRAM refresh sequencer are outside this block. Each one meets the arbiter through a plain request/done pair. All pins are plain control signals. No data stream passes through the block, so there is no valid/ready back-pressure at its edge. A configuration write strobe loads the number of active local pairs and the per-channel DMA mask.

Top module: `sysbus_arb`

## Requirements
- R1: After reset, HOLD is low, every local grant is high (inactive), no DMA grant is set and the refresh go strobe is low. One local pair is active, and every DMA channel is masked: mask bit i set to 1 masks channel i.
- R2: While the processor owns the bus and no unmasked DMA request is pending, the lowest-index active local request (lreq_n bit low) gets its lgnt_n bit low one clock after the request is seen. The grant is held while that request stays low and is removed one clock after it goes high.
- R3: Writing cfg_nlocal with cfg_we high sets the number of active local pairs. Only pairs 0 to N-1 can be granted; a value of 0 counts as 1 and values above the maximum are clipped to it.
- R4: A DMA channel whose mask bit is 1 is ignored: its request neither raises HOLD, wins a DMA grant nor pre-empts a local master.
- R5: With the processor as owner, lock low and hold acknowledge low, an unmasked DMA request raises HOLD one clock later. A one-hot DMA grant for the lowest-index unmasked requesting channel follows two clocks after hold acknowledge goes high, and never without it.
- R6: When the granted channel's request line goes high, the DMA grant and HOLD both drop one clock later.
- R7: An unmasked DMA request while a local master owns the bus removes that master's grant one clock later. HOLD rises one clock after the master releases its request, or 32 clocks after the grant was removed if the master keeps requesting. HOLD and a local grant are never active together.
- R8: While lock is high, HOLD is never raised; pending DMA requests wait and HOLD rises one clock after lock falls.
- R9: A refresh request gives a single-cycle ref_go while the processor or a local master owns the bus, without changing HOLD or the local grant. No ref_go occurs while HOLD is high. After a go, no further go is issued until ref_done. A request that arrives while a refresh is busy is kept and served after ref_done.
- R10: Priority is processor reset request, then refresh, then DMA/ISA, then local masters by index. cpu_rst_req removes a local grant one clock later and blocks new grants, HOLD and refresh while high. A refresh request and a DMA request arriving together give ref_go first and HOLD one clock later. A DMA request and a local request arriving together give HOLD and no local grant.
- R11: After a DMA transfer, HOLD is not raised again until hold acknowledge has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Load configuration on this clock |
| cfg_nlocal | input | LCW | Number of active local request/grant pairs |
| cfg_mask | input | NUM_DMA | Per-channel DMA mask, 1 = masked |
| cpu_rst_req | input | 1 | Processor reset request, highest priority |
| lock | input | 1 | Blocks HOLD while high |
| dreq_n | input | NUM_DMA | Active-low DMA/ISA channel requests |
| dgnt | output | NUM_DMA | One-hot DMA/ISA grant |
| hold | output | 1 | HOLD request to the processor |
| hlda | input | 1 | Hold acknowledge from the processor |
| lreq_n | input | MAX_LOCAL | Active-low local master requests |
| lgnt_n | output | MAX_LOCAL | Active-low local master grants |
| ref_req | input | 1 | Refresh request from the refresh timer |
| ref_done | input | 1 | Refresh cycle finished |
| ref_go | output | 1 | One-cycle strobe that starts a refresh |

## Verification
A wrong ownership state shows up within one clock as HOLD and a local grant active together, a grant on the wrong line, or HOLD failing to drop after a release. The clock-exact checks on every edge of the handshake catch it there. A bad pre-emption counter shows only at the timeout edge, so the bench counts the 32-clock window exactly. A stuck refresh busy flag hides until the next request, when ref_go fails to appear or appears twice. Randomised channel, mask and local-count patterns check the lowest-index selection against a bench function.

// File: rtl/sysbus_arb_pkg.sv
package sysbus_arb_pkg;

  typedef enum logic [2:0] {
    ST_CPU  = 3'd0,
    ST_LOC  = 3'd1,
    ST_PRE  = 3'd2,
    ST_HOLD = 3'd3,
    ST_DMA  = 3'd4
  } arb_state_e;

  function automatic logic owner_is_hidden_ok(arb_state_e s);
    return (s == ST_CPU) || (s == ST_LOC);
  endfunction

endpackage

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/arb_cfg.sv
module arb_cfg #(
  parameter int NUM_DMA   = 4,
  parameter int MAX_LOCAL = 3,
  localparam int LCW = $clog2(MAX_LOCAL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [LCW-1:0]       cfg_nlocal,
  input  logic [NUM_DMA-1:0]   cfg_mask,
  output logic [NUM_DMA-1:0]   mask_q,
  output logic [MAX_LOCAL-1:0] loc_en
);
  logic [LCW-1:0] nloc_q;
  logic [LCW-1:0] nloc_clip;

  always_comb begin
    if (cfg_nlocal == '0)
      nloc_clip = LCW'(1);
    else if (cfg_nlocal > LCW'(MAX_LOCAL))
      nloc_clip = LCW'(MAX_LOCAL);
    else
      nloc_clip = cfg_nlocal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nloc_q <= LCW'(1);
      mask_q <= '1;
    end else if (cfg_we) begin
      nloc_q <= nloc_clip;
      mask_q <= cfg_mask;
    end
  end

  for (genvar g = 0; g < MAX_LOCAL; g++) begin : g_en
    assign loc_en[g] = (LCW'(g) < nloc_q);
  end
endmodule

// File: rtl/refresh_ctl.sv
module refresh_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_req,
  input  logic ref_done,
  input  logic allow,
  output logic ref_want,
  output logic ref_go
);
  logic pend_q;
  logic busy_q;
  logic fire;

  assign ref_want = (pend_q | ref_req) & ~busy_q;
  assign fire     = ref_want & allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      ref_go <= 1'b0;
    end else begin
      pend_q <= (pend_q | ref_req) & ~fire;
      ref_go <= fire;
      if (fire)
        busy_q <= 1'b1;
      else if (ref_done)
        busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sysbus_arb.sv
module sysbus_arb
  import sysbus_arb_pkg::*;
#(
  parameter int NUM_DMA   = 4,
  parameter int MAX_LOCAL = 3,
  parameter int TIMEOUT   = 32,
  localparam int LCW = $clog2(MAX_LOCAL + 1),
  localparam int LIW = (MAX_LOCAL > 1) ? $clog2(MAX_LOCAL) : 1,
  localparam int DIW = (NUM_DMA > 1) ? $clog2(NUM_DMA) : 1,
  localparam int CW  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [LCW-1:0]       cfg_nlocal,
  input  logic [NUM_DMA-1:0]   cfg_mask,
  input  logic                 cpu_rst_req,
  input  logic                 lock,
  input  logic [NUM_DMA-1:0]   dreq_n,
  output logic [NUM_DMA-1:0]   dgnt,
  output logic                 hold,
  input  logic                 hlda,
  input  logic [MAX_LOCAL-1:0] lreq_n,
  output logic [MAX_LOCAL-1:0] lgnt_n,
  input  logic                 ref_req,
  input  logic                 ref_done,
  output logic                 ref_go
);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

  logic [NUM_DMA-1:0]   dma_mask;
  logic [MAX_LOCAL-1:0] loc_en;
  logic [NUM_DMA-1:0]   dma_req;
  logic [MAX_LOCAL-1:0] loc_req;
  logic                 dma_any, loc_any;
  logic [DIW-1:0]       dma_pick;
  logic [LIW-1:0]       loc_pick;
  logic                 ref_want, ref_allow;
  logic                 hlda_q;

  arb_state_e     st, nxt;
  logic [LIW-1:0] lidx, lidx_n;
  logic [DIW-1:0] dch, dch_n;
  logic [CW-1:0]  cnt, cnt_n;

  arb_cfg #(.NUM_DMA(NUM_DMA), .MAX_LOCAL(MAX_LOCAL)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_nlocal(cfg_nlocal),
    .cfg_mask(cfg_mask), .mask_q(dma_mask), .loc_en(loc_en)
  );

  assign dma_req = ~dreq_n & ~dma_mask;
  assign loc_req = ~lreq_n & loc_en;

  lowest_pick #(.N(NUM_DMA)) u_dpick (.req(dma_req), .any(dma_any), .idx(dma_pick));
  lowest_pick #(.N(MAX_LOCAL)) u_lpick (.req(loc_req), .any(loc_any), .idx(loc_pick));

  assign ref_allow = owner_is_hidden_ok(nxt) & ~cpu_rst_req;

  refresh_ctl u_ref (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_done(ref_done),
    .allow(ref_allow), .ref_want(ref_want), .ref_go(ref_go)
  );

  always_comb begin
    nxt    = st;
    lidx_n = lidx;
    dch_n  = dch;
    cnt_n  = cnt;
    case (st)
      ST_CPU: begin
        if (!cpu_rst_req && !ref_want) begin
          if (dma_any) begin
            if (!lock && !hlda_q) nxt = ST_HOLD;
          end else if (loc_any) begin
            nxt    = ST_LOC;
            lidx_n = loc_pick;
          end
        end
      end
      ST_LOC: begin
        if (cpu_rst_req || !loc_en[lidx]) begin
          nxt = ST_CPU;
        end else if (dma_any) begin
          nxt   = ST_PRE;
          cnt_n = '0;
        end else if (lreq_n[lidx]) begin
          nxt = ST_CPU;
        end
      end
      ST_PRE: begin
        if (lreq_n[lidx] || cnt == CNT_LAST) begin
          if (dma_any && !lock && !cpu_rst_req && !hlda_q) nxt = ST_HOLD;
          else                                             nxt = ST_CPU;
        end else begin
          cnt_n = cnt + CW'(1);
        end
      end
      ST_HOLD: begin
        if (cpu_rst_req || !dma_any) begin
          nxt = ST_CPU;
        end else if (hlda_q) begin
          nxt   = ST_DMA;
          dch_n = dma_pick;
        end
      end
      ST_DMA: begin
        if (dreq_n[dch] || dma_mask[dch]) nxt = ST_CPU;
      end
      default: nxt = ST_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_CPU;
      lidx   <= '0;
      dch    <= '0;
      cnt    <= '0;
      hlda_q <= 1'b0;
    end else begin
      st     <= nxt;
      lidx   <= lidx_n;
      dch    <= dch_n;
      cnt    <= cnt_n;
      hlda_q <= hlda;
    end
  end

  assign hold = (st == ST_HOLD) || (st == ST_DMA);

  for (genvar g = 0; g < MAX_LOCAL; g++) begin : g_lgnt
    assign lgnt_n[g] = !((st == ST_LOC) && (lidx == LIW'(g)));
  end

  for (genvar g = 0; g < NUM_DMA; g++) begin : g_dgnt
    assign dgnt[g] = (st == ST_DMA) && (dch == DIW'(g));
  end
endmodule

// File: rtl/sysbus_arb_chk.sv
module sysbus_arb_chk #(
  parameter int NUM_DMA   = 4,
  parameter int MAX_LOCAL = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hold,
  input logic                 hlda,
  input logic                 lock,
  input logic                 ref_go,
  input logic [NUM_DMA-1:0]   dgnt,
  input logic [NUM_DMA-1:0]   dreq_n,
  input logic [NUM_DMA-1:0]   dma_mask,
  input logic [MAX_LOCAL-1:0] lgnt_n
);
  assert_no_dual_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (&lgnt_n));

  assert_dgnt_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dgnt) |-> (hold && $onehot0(dgnt)));

  assert_grant_after_hlda_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dgnt) |-> $past(hlda, 2));

  assert_masked_no_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|dgnt) && $stable(dma_mask)) |-> ((dgnt & dma_mask) == '0));

  assert_release_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dgnt & dreq_n)) |=> (!hold && (dgnt == '0)));

  assert_lock_blocks_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !hold) |=> !hold);

  assert_ref_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_go |-> !hold);

  assert_ref_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_go |=> !ref_go);
endmodule

bind sysbus_arb sysbus_arb_chk #(.NUM_DMA(NUM_DMA), .MAX_LOCAL(MAX_LOCAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .hlda(hlda), .lock(lock),
  .ref_go(ref_go), .dgnt(dgnt), .dreq_n(dreq_n), .dma_mask(dma_mask),
  .lgnt_n(lgnt_n)
);

// File: tb/sysbus_arb_tb.sv
`timescale 1ns/1ps
module sysbus_arb_tb;
  localparam int ND = 4;
  localparam int NL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_nlocal = 2'd1;
  logic [ND-1:0] cfg_mask = '1;
  logic          cpu_rst_req = 1'b0;
  logic          lock = 1'b0;
  logic [ND-1:0] dreq_n = '1;
  logic [ND-1:0] dgnt;
  logic          hold;
  logic          hlda = 1'b0;
  logic [NL-1:0] lreq_n = '1;
  logic [NL-1:0] lgnt_n;
  logic          ref_req = 1'b0;
  logic          ref_done = 1'b0;
  logic          ref_go;

  int vecs = 0;
  int miss = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sysbus_arb #(.NUM_DMA(ND), .MAX_LOCAL(NL), .TIMEOUT(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_nlocal(cfg_nlocal),
    .cfg_mask(cfg_mask), .cpu_rst_req(cpu_rst_req), .lock(lock),
    .dreq_n(dreq_n), .dgnt(dgnt), .hold(hold), .hlda(hlda),
    .lreq_n(lreq_n), .lgnt_n(lgnt_n), .ref_req(ref_req),
    .ref_done(ref_done), .ref_go(ref_go)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] n, input logic [ND-1:0] m);
    cfg_nlocal = n;
    cfg_mask = m;
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  function automatic int lowest(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) lowest = i;
    if (v == 0) lowest = -1;
  endfunction

  function automatic logic [NL-1:0] exp_lgnt(input logic [NL-1:0] req, input int n);
    logic [7:0] m;
    int k;
    m = 8'(req) & 8'((1 << n) - 1);
    k = lowest(m);
    exp_lgnt = (k < 0) ? '1 : ~NL'(1 << k);
  endfunction

  task automatic dma_finish();
    dreq_n = '1;
    hlda = 1'b0;
    step();
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'h5eed);
    step();
    step();
    // R1 reset values
    chk("R1 hold", 32'(hold), 0);
    chk("R1 lgnt_n", 32'(lgnt_n), 32'h7);
    chk("R1 dgnt", 32'(dgnt), 0);
    chk("R1 ref_go", 32'(ref_go), 0);
    rst_n = 1'b1;
    step();
    dreq_n = 4'b1110;
    step();
    chk("R1 masked at reset", 32'(hold), 0);
    dreq_n = '1;
    lreq_n = 3'b101;
    step();
    chk("R3 one pair default", 32'(lgnt_n), 32'h7);
    lreq_n = '1;
    wr_cfg(2'd0, 4'h0);
    lreq_n = 3'b101;
    step();
    chk("R3 zero counts as one", 32'(lgnt_n), 32'h7);
    lreq_n = '1;
    wr_cfg(2'd3, 4'h0);

    // R2 local grant
    lreq_n = 3'b110;
    step();
    chk("R2 grant 0", 32'(lgnt_n), 32'h6);
    lreq_n = 3'b100;
    step();
    chk("R2 grant held", 32'(lgnt_n), 32'h6);
    lreq_n = 3'b101;
    step();
    chk("R2 release", 32'(lgnt_n), 32'h7);
    step();
    chk("R2 next index", 32'(lgnt_n), 32'h5);
    lreq_n = '1;
    step();

    // R10 DMA beats local
    lreq_n = 3'b110;
    dreq_n = 4'b1011;
    step();
    chk("R10 dma wins hold", 32'(hold), 1);
    chk("R10 no local grant", 32'(lgnt_n), 32'h7);
    lreq_n = '1;
    hlda = 1'b1;
    step();
    chk("R5 no grant yet", 32'(dgnt), 0);
    step();
    chk("R5 grant ch2", 32'(dgnt), 32'h4);
    dreq_n = '1;
    step();
    chk("R6 hold drops", 32'(hold), 0);
    chk("R6 dgnt drops", 32'(dgnt), 0);

    // R11 hlda still high
    dreq_n = 4'b1101;
    step();
    chk("R11 wait hlda low a", 32'(hold), 0);
    step();
    chk("R11 wait hlda low b", 32'(hold), 0);
    hlda = 1'b0;
    step();
    chk("R11 wait hlda low c", 32'(hold), 0);
    step();
    chk("R11 hold again", 32'(hold), 1);
    hlda = 1'b1;
    step();
    step();
    chk("R5 grant ch1", 32'(dgnt), 32'h2);
    dma_finish();

    // R7 pre-emption with release
    lreq_n = 3'b110;
    step();
    chk("R7 local owner", 32'(lgnt_n), 32'h6);
    dreq_n = 4'b1110;
    step();
    chk("R7 grant removed", 32'(lgnt_n), 32'h7);
    chk("R7 no hold yet", 32'(hold), 0);
    step();
    chk("R7 waiting", 32'(hold), 0);
    lreq_n = '1;
    step();
    chk("R7 hold after release", 32'(hold), 1);
    dma_finish();

    // R7 pre-emption timeout
    lreq_n = 3'b011;
    step();
    chk("R7 local 2 owner", 32'(lgnt_n), 32'h3);
    dreq_n = 4'b0111;
    step();
    chk("R7 grant removed t", 32'(lgnt_n), 32'h7);
    repeat (31) step();
    chk("R7 before timeout", 32'(hold), 0);
    step();
    chk("R7 timeout hold", 32'(hold), 1);
    lreq_n = '1;
    dma_finish();

    // R4 masked channel
    wr_cfg(2'd3, 4'b0001);
    lreq_n = 3'b110;
    step();
    dreq_n = 4'b1110;
    step();
    chk("R4 no preempt", 32'(lgnt_n), 32'h6);
    lreq_n = '1;
    step();
    step();
    chk("R4 no hold masked", 32'(hold), 0);
    dreq_n = 4'b1100;
    step();
    hlda = 1'b1;
    step();
    step();
    chk("R4 skip masked ch", 32'(dgnt), 32'h2);
    dma_finish();
    wr_cfg(2'd3, 4'h0);

    // R8 lock
    lock = 1'b1;
    dreq_n = 4'b1110;
    step();
    step();
    step();
    chk("R8 locked", 32'(hold), 0);
    lock = 1'b0;
    step();
    chk("R8 released", 32'(hold), 1);
    dma_finish();

    // R9 refresh while CPU owns
    ref_req = 1'b1;
    step();
    ref_req = 1'b0;
    chk("R9 go", 32'(ref_go), 1);
    chk("R9 hold untouched", 32'(hold), 0);
    step();
    chk("R9 single pulse", 32'(ref_go), 0);
    ref_req = 1'b1;
    step();
    ref_req = 1'b0;
    chk("R9 busy blocks", 32'(ref_go), 0);
    ref_done = 1'b1;
    step();
    ref_done = 1'b0;
    chk("R9 done edge", 32'(ref_go), 0);
    step();
    chk("R9 kept request served", 32'(ref_go), 1);
    ref_done = 1'b1;
    step();
    ref_done = 1'b0;
    // R9 under local owner
    lreq_n = 3'b110;
    step();
    ref_req = 1'b1;
    step();
    ref_req = 1'b0;
    chk("R9 go local owner", 32'(ref_go), 1);
    chk("R9 local kept", 32'(lgnt_n), 32'h6);
    lreq_n = '1;
    ref_done = 1'b1;
    step();
    ref_done = 1'b0;
    step();
    // R9 during DMA
    dreq_n = 4'b1110;
    step();
    hlda = 1'b1;
    step();
    step();
    ref_req = 1'b1;
    step();
    ref_req = 1'b0;
    step();
    chk("R9 no go in dma", 32'(ref_go), 0);
    dreq_n = '1;
    hlda = 1'b0;
    step();
    chk("R9 go after dma", 32'(ref_go), 1);
    chk("R9 hold low", 32'(hold), 0);
    ref_done = 1'b1;
    step();
    ref_done = 1'b0;
    step();

    // R10 refresh before DMA
    ref_req = 1'b1;
    dreq_n = 4'b1110;
    step();
    ref_req = 1'b0;
    chk("R10 refresh first", 32'(ref_go), 1);
    chk("R10 hold after refresh", 32'(hold), 0);
    step();
    chk("R10 hold next", 32'(hold), 1);
    ref_done = 1'b1;
    dma_finish();
    ref_done = 1'b0;

    // R10 cpu reset request
    lreq_n = 3'b110;
    step();
    cpu_rst_req = 1'b1;
    step();
    chk("R10 reset drops local", 32'(lgnt_n), 32'h7);
    ref_req = 1'b1;
    dreq_n = 4'b1110;
    step();
    ref_req = 1'b0;
    chk("R10 reset blocks go", 32'(ref_go), 0);
    chk("R10 reset blocks hold", 32'(hold), 0);
    lreq_n = '1;
    cpu_rst_req = 1'b0;
    step();
    chk("R10 go after reset", 32'(ref_go), 1);
    ref_done = 1'b1;
    step();
    ref_done = 1'b0;
    chk("R10 hold after go", 32'(hold), 1);
    dma_finish();

    // R3 clip above max
    wr_cfg(2'd3, 4'hf);
    lreq_n = 3'b011;
    step();
    chk("R3 pair 2 active", 32'(lgnt_n), 32'h3);
    lreq_n = '1;
    step();

    // random local patterns (R2, R3)
    for (int it = 0; it < 40; it++) begin
      int n;
      logic [NL-1:0] p;
      n = 1 + ($urandom % 3);
      p = NL'($urandom);
      wr_cfg(2'(n), 4'hf);
      lreq_n = ~p;
      step();
      chk("R3 random local", 32'(lgnt_n), 32'(exp_lgnt(p, n)));
      lreq_n = '1;
      step();
      step();
    end

    // random DMA patterns (R4, R5)
    for (int it = 0; it < 40; it++) begin
      logic [ND-1:0] m, p;
      int k;
      m = ND'($urandom);
      p = ND'($urandom);
      k = $urandom % ND;
      m[k] = 1'b0;
      p[k] = 1'b1;
      wr_cfg(2'd1, m);
      dreq_n = ~p;
      step();
      chk("R5 random hold", 32'(hold), 1);
      hlda = 1'b1;
      step();
      step();
      chk("R4 random grant", 32'(dgnt), 32'(1 << lowest(8'(p & ~m))));
      dma_finish();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule